// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Generator

This block turns an angle into its cosine and sine through circular rotation by shift-and-add steps. An angle word comes in with a valid bit. It passes through a chain of identical rotation stages, one stage per bit of word width. Exactly that many clocks later, the two results appear with their own valid bit. A new angle can be accepted on every clock. Each stage rotates the running vector by a fixed elementary angle, either clockwise or anticlockwise. The direction follows the sign of the angle that is still left to cover. The per-stage angles are constants, computed when the design is elaborated.

The vector does not start at (1, 0). It starts at (1/K, 0), where K is the product of the per-stage stretch factors, roughly 1.6468. The vector therefore reaches unit length at the last stage, and no output multiplier is needed. The angle is a signed degree value with nine integer bits and W-9 fractional bits. The results are signed values with two integer bits and W-2 fractional bits. Only angles whose magnitude does not exceed about 99.9 degrees converge.

Top module: `cordic_sincos`

## Requirements
- R1: The latency is exactly W clocks. A sample accepted with in_valid high at one rising edge raises out_valid after the W-th rising edge, counted from and including that edge. out_valid is low on every other clock, unless another sample causes it.
- R2: A synchronous active-high rst clears all valid stages. out_valid is low after any clock edge that samples rst high, and it stays low until a valid sample taken after reset has covered the full latency.
- R3: An angle of 0 gives cos_o within 8 LSB of 2^(W-2) (1.0) and sin_o within 8 LSB of 0.
- R4: Positive angles of 30, 45, 60 and 90 degrees give cosine and sine within 8 LSB of the real values scaled by 2^(W-2). At W=16, 60 degrees is the angle word 16'h1E00.
- R5: A negative angle gives the same cosine as the matching positive angle and a sine of opposite sign, within 8 LSB. This is checked at -30, -60 and -90 degrees.
- R6: Angles near the edge of the convergence range (+99 and -99 degrees) still give results within 8 LSB, with a negative cosine.
- R7: The angle word is two's complement degrees with W-9 fractional bits. The integer value deg·2^(W-9) stands for deg degrees.
- R8: The outputs are two's complement with W-2 fractional bits and need no further scaling. Internal values that go beyond the W-bit range saturate instead of wrapping.
- R9: Back-to-back samples, one per clock, come out on consecutive clocks in the order they went in, each with its own result.
- R10: A clock with in_valid low produces a clock with out_valid low exactly W clocks later, so gaps in the input stream appear unchanged at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Angle word is valid this clock |
| angle_i | input | W | Signed angle, degrees, W-9 fractional bits |
| out_valid | output | 1 | Results are valid this clock |
| cos_o | output | W | Cosine, signed, W-2 fractional bits |
| sin_o | output | W | Sine, signed, W-2 fractional bits |

## Verification
The hardest case to reach from the ports is a pipeline that holds several samples at different depths while valid and idle slots are mixed. In that state a stage that mis-tracks its valid bit, or a sample that is routed into the wrong slot, looks correct in single-sample tests. The stimulus streams a per-clock pattern of valid bits and angles, with gaps, and keeps driving while earlier samples are still in flight. It checks every output clock against the pattern delayed by W. A reset asserted while the pipeline is full shows that no result survives it.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam real PI          = 3.14159265358979323846;
    // integer bits (sign included) of the degree-valued angle word
    localparam int  ANG_INT_BITS = 9;
    // extra fractional bits carried on the residual angle
    localparam int  Z_GUARD      = 4;
    // extra integer bits carried on the x / y datapath
    localparam int  XY_GUARD     = 2;

    // elementary angle atan(2^-idx) in degrees, scaled by 2^frac_bits
    function automatic longint atan_deg_code(input int idx, input int frac_bits);
        real deg;
        deg = $atan(2.0 ** (-idx)) * 180.0 / PI;
        return longint'(deg * (2.0 ** frac_bits));
    endfunction

    // 1/K for n_iter micro-rotations, scaled by 2^frac_bits
    function automatic longint inv_gain_code(input int n_iter, input int frac_bits);
        real g;
        g = 1.0;
        for (int k = 0; k < n_iter; k++) begin
            g = g / $sqrt(1.0 + 2.0 ** (-2 * k));
        end
        return longint'(g * (2.0 ** frac_bits));
    endfunction

endpackage

// File: rtl/cordic_seed.sv
module cordic_seed #(
    parameter int W  = 16,
    parameter int XW = 18,
    parameter int ZW = 20
) (
    input  logic [W-1:0]          angle_i,
    output logic signed [XW-1:0]  x0_o,
    output logic signed [XW-1:0]  y0_o,
    output logic signed [ZW-1:0]  z0_o
);
    import cordic_pkg::*;

    localparam int     FB     = W - 2;
    localparam int     ZPAD   = ZW - W;
    localparam longint X0_RAW = inv_gain_code(W, FB);
    localparam logic signed [XW-1:0] X0 = X0_RAW[XW-1:0];

    always_comb begin
        x0_o = X0;
        y0_o = '0;
        z0_o = {angle_i, {ZPAD{1'b0}}};
    end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int     XW   = 18,
    parameter int     ZW   = 20,
    parameter int     IDX  = 0,
    parameter longint ATAN = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vld_i,
    input  logic signed [XW-1:0]  x_i,
    input  logic signed [XW-1:0]  y_i,
    input  logic signed [ZW-1:0]  z_i,
    output logic                  vld_o,
    output logic signed [XW-1:0]  x_o,
    output logic signed [XW-1:0]  y_o,
    output logic signed [ZW-1:0]  z_o
);
    localparam logic signed [ZW-1:0] STEP = ATAN[ZW-1:0];

    typedef struct packed {
        logic                 vld;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } stage_t;

    stage_t               st_d, st_q;
    logic signed [XW-1:0] x_sh, y_sh;

    always_comb begin
        x_sh   = x_i >>> IDX;
        y_sh   = y_i >>> IDX;
        st_d.vld = vld_i;
        if (!z_i[ZW-1]) begin
            // residual non-negative: turn anticlockwise
            st_d.x = x_i - y_sh;
            st_d.y = y_i + x_sh;
            st_d.z = z_i - STEP;
        end else begin
            st_d.x = x_i + y_sh;
            st_d.y = y_i - x_sh;
            st_d.z = z_i + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;

endmodule

// File: rtl/cordic_outsat.sv
module cordic_outsat #(
    parameter int XW = 18,
    parameter int W  = 16
) (
    input  logic signed [XW-1:0] val_i,
    output logic [W-1:0]         val_o
);
    localparam logic signed [XW-1:0] HI = XW'((longint'(1) <<< (W - 1)) - 1);
    localparam logic signed [XW-1:0] LO = -XW'(longint'(1) <<< (W - 1));

    always_comb begin
        if (val_i > HI)      val_o = HI[W-1:0];
        else if (val_i < LO) val_o = LO[W-1:0];
        else                 val_o = val_i[W-1:0];
    end

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] angle_i,
    output logic         out_valid,
    output logic [W-1:0] cos_o,
    output logic [W-1:0] sin_o
);
    import cordic_pkg::*;

    localparam int XW   = W + XY_GUARD;
    localparam int ZW   = W + Z_GUARD;
    localparam int ZF   = W - ANG_INT_BITS + Z_GUARD;
    localparam int NSTG = W;

    logic                 vld_s [NSTG+1];
    logic signed [XW-1:0] x_s   [NSTG+1];
    logic signed [XW-1:0] y_s   [NSTG+1];
    logic signed [ZW-1:0] z_s   [NSTG+1];

    assign vld_s[0] = in_valid;

    cordic_seed #(.W(W), .XW(XW), .ZW(ZW)) u_seed (
        .angle_i (angle_i),
        .x0_o    (x_s[0]),
        .y0_o    (y_s[0]),
        .z0_o    (z_s[0])
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        cordic_stage #(
            .XW   (XW),
            .ZW   (ZW),
            .IDX  (g),
            .ATAN (atan_deg_code(g, ZF))
        ) u_stage (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vld_s[g]),
            .x_i   (x_s[g]),
            .y_i   (y_s[g]),
            .z_i   (z_s[g]),
            .vld_o (vld_s[g+1]),
            .x_o   (x_s[g+1]),
            .y_o   (y_s[g+1]),
            .z_o   (z_s[g+1])
        );
    end

    cordic_outsat #(.XW(XW), .W(W)) u_sat_cos (.val_i(x_s[NSTG]), .val_o(cos_o));
    cordic_outsat #(.XW(XW), .W(W)) u_sat_sin (.val_i(y_s[NSTG]), .val_o(sin_o));

    assign out_valid = vld_s[NSTG];

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] angle_i,
    input logic         out_valid,
    input logic [W-1:0] cos_o,
    input logic [W-1:0] sin_o
);
    localparam int ONE_DEG = 1 << (W - 9);
    localparam int UNIT    = 1 << (W - 2);
    localparam int LIM     = UNIT + 16;

    logic [W-1:0]        vld_hist;
    logic signed [W-1:0] ang_hist [W];
    logic signed [W-1:0] ang_out;

    always_ff @(posedge clk) begin
        if (rst) vld_hist <= '0;
        else     vld_hist <= {vld_hist[W-2:0], in_valid};
        ang_hist[0] <= angle_i;
        for (int k = 1; k < W; k++) ang_hist[k] <= ang_hist[k-1];
    end

    assign ang_out = ang_hist[W-1];

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_hist[W-1]);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R8
    range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(cos_o) <= LIM && $signed(cos_o) >= -LIM &&
                       $signed(sin_o) <= LIM && $signed(sin_o) >= -LIM));

    // R5
    sine_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ang_out >= ONE_DEG) |-> $signed(sin_o) > 0);

    // R5
    sine_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ang_out <= -ONE_DEG) |-> $signed(sin_o) < 0);

    // R4
    cos_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ang_out <= 80 * ONE_DEG && ang_out >= -80 * ONE_DEG)
            |-> $signed(cos_o) > 0);

    // R6
    cos_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (ang_out >= 92 * ONE_DEG || ang_out <= -92 * ONE_DEG))
            |-> $signed(cos_o) < 0);

endmodule

bind cordic_sincos cordic_sincos_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .angle_i   (angle_i),
    .out_valid (out_valid),
    .cos_o     (cos_o),
    .sin_o     (sin_o)
);

// File: tb/tb_cordic_sincos.sv
`timescale 1ns/1ps
module tb_cordic_sincos;
    localparam int  W       = 16;
    localparam int  FRAC_A  = W - 9;
    localparam real UNIT    = real'(1 << (W - 2));
    localparam real TOL     = 8.0;
    localparam real PI      = 3.14159265358979323846;
    localparam int  MAXN    = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] angle_i = '0;
    logic         out_valid;
    logic [W-1:0] cos_o, sin_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] s_ang [MAXN];
    logic         s_vld [MAXN];
    int           s_n;

    always #10 clk = ~clk;

    cordic_sincos #(.W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .angle_i(angle_i),
        .out_valid(out_valid), .cos_o(cos_o), .sin_o(sin_o)
    );

    function automatic logic [W-1:0] deg_word(input int deg);
        return W'(deg * (1 << FRAC_A));
    endfunction

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input logic [W-1:0] act, input real exp);
        real a;
        a = real'($signed(act));
        checks++;
        if ((a - exp > TOL) || (exp - a > TOL)) begin
            errors++;
            $display("FAIL %s actual %0d expected %0.2f", tag, $signed(act), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drives s_vld/s_ang one per clock, checks every output slot
    task automatic run_stream(input string tag);
        for (int j = 0; j <= s_n + W; j++) begin
            if (j >= W) begin
                int k;
                logic ev;
                real deg;
                k  = j - W;
                ev = (k < s_n) ? s_vld[k] : 1'b0;
                chk_bit({tag, " valid"}, out_valid, ev);
                if (ev) begin
                    deg = real'($signed(s_ang[k])) / real'(1 << FRAC_A);
                    chk_near({tag, " cos"}, cos_o, $cos(deg * PI / 180.0) * UNIT);
                    chk_near({tag, " sin"}, sin_o, $sin(deg * PI / 180.0) * UNIT);
                end
            end else begin
                chk_bit({tag, " R1 early valid"}, out_valid, 1'b0);
            end
            if (j < s_n) begin
                in_valid = s_vld[j];
                angle_i  = s_ang[j];
            end else begin
                in_valid = 1'b0;
                angle_i  = '0;
            end
            @(negedge clk);
        end
    endtask

    task automatic one_angle(input string tag, input logic [W-1:0] a);
        s_n = 1;
        s_vld[0] = 1'b1;
        s_ang[0] = a;
        run_stream(tag);
    endtask

    task automatic t_reset_state();
        for (int c = 0; c < W + 2; c++) begin
            chk_bit("R2 idle after reset", out_valid, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic t_zero();
        one_angle("R3 zero", '0);
    endtask

    task automatic t_positive();
        one_angle("R4 p30", deg_word(30));
        one_angle("R4 p45", deg_word(45));
        one_angle("R4 R7 p60 literal", 16'h1E00);
        one_angle("R4 p90", deg_word(90));
    endtask

    task automatic t_negative();
        one_angle("R5 n30", deg_word(-30));
        one_angle("R5 n60", deg_word(-60));
        one_angle("R5 n90", deg_word(-90));
    endtask

    task automatic t_edge_range();
        one_angle("R6 p99", deg_word(99));
        one_angle("R6 n99", deg_word(-99));
        one_angle("R7 R8 fractional 12.5", W'(25 * (1 << (FRAC_A - 1))));
    endtask

    task automatic t_back_to_back();
        int degs [8] = '{0, 15, -45, 75, -80, 60, -10, 90};
        s_n = 8;
        for (int i = 0; i < 8; i++) begin
            s_vld[i] = 1'b1;
            s_ang[i] = deg_word(degs[i]);
        end
        run_stream("R9 stream");
    endtask

    task automatic t_bubbles();
        s_n = 12;
        for (int i = 0; i < 12; i++) begin
            s_vld[i] = (i % 3 != 1);
            s_ang[i] = deg_word(i * 17 - 90);
        end
        run_stream("R10 gaps");
    endtask

    task automatic t_reset_midflight();
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1;
            angle_i  = deg_word(20 * i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < W + 2; c++) begin
            chk_bit("R2 flushed by reset", out_valid, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_zero();
        t_positive();
        t_negative();
        t_edge_range();
        t_back_to_back();
        t_bubbles();
        t_reset_midflight();
        one_angle("R1 after reset", deg_word(30));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule